// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block watches the five control strobes of an asynchronous DRAM bus (row strobe, upper and lower column strobes, write enable and output enable) from a synchronous clock domain. It resynchronises the strobes and follows the order in which their edges arrive. At the end of every row-strobe-low period it reports what kind of cycle the bus controller ran. The report holds a cycle-type code, one flag per byte lane that was accessed, and the number of column accesses made while the row stayed open. A one-clock done pulse marks each report.

The two column strobes act as one combined strobe when deciding the mode of an access. An access starts when either strobe falls while both were high, and it ends when both are high again. The write mode and lane participation are still tracked per lane, so a lane can be left unaccessed and a mismatch between lanes can be detected. The time thresholds that separate refresh flavours are given in sample clocks.

Top module: `dram_cycle_classifier`

## Requirements
- R1: After reset the code output is 0 (none), both lane flags are 0, the access count is 0 and the done strobe is low.
- R2: Done is a single-clock pulse raised once per row-strobe-low period, after the row strobe returns high. The code, lane flags and count hold their values until the next pulse.
- R3: A period in which both column strobes stay high from start to end reports code 6 (row-only refresh), with both lane flags 0 and an access count of 0.
- R4: A period that begins with either column strobe already low reports code 7 (strobe-first refresh) when its length is below BAD_MIN_CLKS. This includes a strobe held low from the previous cycle (hidden refresh). Lane flags and access count are 0.
- R5: A strobe-first period lasting at least SELF_MIN_CLKS reports code 8 (self refresh), with lane flags 0.
- R6: An access with write enable high throughout reports code 1 (read) if output enable was low at some point during the access, and code 2 (read, output disabled) if output enable stayed high.
- R7: Write enable low at or before the falling edge of a lane's column strobe makes that lane an early write, code 3.
- R8: Write enable falling after the column strobe fell, with output enable never low earlier in the access, is a delayed write, code 4.
- R9: Write enable falling after output enable was low earlier in the same access is a read-modify-write, code 5.
- R10: The lower flag (bit lane 0, strobe lcas_n) and the upper flag (lane 1, strobe ucas_n) are set for each lane whose column strobe went low during the period. An access on one lane sets only that lane's flag.
- R11: The access count equals the number of access starts in the period (combined column strobe going from both-high to any-low). When a period holds several accesses, the reported code is that of the last access.
- R12: Code 9 (protocol error) is reported when, within one access, the two lanes end up with different modes.
- R13: Code 9 is reported when a column strobe falls while the row strobe is high and both column strobes are high again by the time the row strobe falls.
- R14: Code 9 is reported for a strobe-first period whose length is at least BAD_MIN_CLKS but below SELF_MIN_CLKS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| cyc_code | output | 4 | Cycle-type code of the last finished period |
| lane_hi | output | 1 | Upper lane accessed in that period |
| lane_lo | output | 1 | Lower lane accessed in that period |
| page_cnt | output | CNT_W | Number of column accesses in that period |
| cyc_done | output | 1 | One-clock pulse when a new report is valid |

## Verification
The bench builds the block with SELF_MIN_CLKS = 40, BAD_MIN_CLKS = 20, two synchroniser stages and a 4-bit count. With these values, ordinary refresh, the forbidden transition band and self refresh all fit in periods of a few dozen sample clocks. This lets every refresh flavour and the band error be reached in one short run next to the read, write and page sequences. The default thresholds, which correspond to tens of microseconds, would not allow that.

// File: rtl/dcc_pkg.sv
// Shared types for the DRAM strobe cycle classifier.
// Assumes: codes are consumed by software-free monitors only.
package dcc_pkg;

    typedef enum logic [3:0] {
        CYC_NONE       = 4'd0,
        CYC_READ       = 4'd1,
        CYC_READ_NOOUT = 4'd2,
        CYC_EARLY_WR   = 4'd3,
        CYC_DELAYED_WR = 4'd4,
        CYC_RMW        = 4'd5,
        CYC_ROW_REF    = 4'd6,
        CYC_CBR_REF    = 4'd7,
        CYC_SELF_REF   = 4'd8,
        CYC_PROTO_ERR  = 4'd9
    } cyc_code_e;

    typedef enum logic [2:0] {
        LM_IDLE    = 3'd0,
        LM_READ    = 3'd1,
        LM_EARLY   = 3'd2,
        LM_DELAYED = 3'd3,
        LM_RMW     = 3'd4
    } lane_mode_e;

    // Maps a lane mode and the output-enable history to a report code.
    function automatic cyc_code_e mode_to_code(input lane_mode_e m, input logic oe_seen);
        case (m)
            LM_READ:    return oe_seen ? CYC_READ : CYC_READ_NOOUT;
            LM_EARLY:   return CYC_EARLY_WR;
            LM_DELAYED: return CYC_DELAYED_WR;
            LM_RMW:     return CYC_RMW;
            default:    return CYC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dcc_sync.sv
// Multi-stage resynchroniser for a vector of active-low strobes.
// Assumes: each bit is an independent level; reset value is inactive (high).
module dcc_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    // First stage samples the asynchronous pins.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= '1;
        else        pipe[0] <= d;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            // Further stages shift the sample along.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[s] <= '1;
                else        pipe[s] <= pipe[s-1];
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/dcc_lane_track.sv
// Per-lane write-mode tracker for one column strobe.
// Decides, for the current access, whether the lane reads, writes early,
// writes late, or does a read-modify-write.
// Assumes: strobes are already synchronised; edges are one-sample events.
module dcc_lane_track
    import dcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       trk_en,
    input  logic       acc_start,
    input  logic       cas_s,
    input  logic       cas_p,
    input  logic       we_s,
    input  logic       we_fall,
    input  logic       oe_seen,
    output lane_mode_e mode
);
    logic lane_fall;
    assign lane_fall = cas_p & ~cas_s;

    // Updates the lane mode on strobe and write-enable edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= LM_IDLE;
        end else if (clr) begin
            mode <= LM_IDLE;
        end else if (trk_en) begin
            if (lane_fall)
                mode <= we_s ? LM_READ : LM_EARLY;
            else if (acc_start)
                mode <= LM_IDLE;
            else if (!cas_s && we_fall && mode == LM_READ)
                mode <= oe_seen ? LM_RMW : LM_DELAYED;
        end
    end
endmodule

// File: rtl/dcc_period.sv
// Row-period bookkeeping: refresh entry, access counting, width timing,
// error collection and the registered report issued when the row closes.
// Assumes: a row period lasts at least one sample; thresholds are in clocks.
module dcc_period
    import dcc_pkg::*;
#(
    parameter int SELF_MIN_CLKS = 20000,
    parameter int BAD_MIN_CLKS  = 2000,
    parameter int CNT_W         = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ras_fall,
    input  logic                  ras_rise,
    input  logic                  row_act,
    input  logic                  row_idle,
    input  logic [1:0]            cas_s,
    input  logic [1:0]            cas_p,
    input  logic                  oe_s,
    input  lane_mode_e [1:0]      modes,
    output logic                  trk_en,
    output logic                  acc_start,
    output logic                  oe_seen,
    output cyc_code_e             code,
    output logic                  lane_hi,
    output logic                  lane_lo,
    output logic [CNT_W-1:0]      cnt,
    output logic                  done
);
    localparam int TIMER_W = $clog2(SELF_MIN_CLKS + 1);
    localparam logic [TIMER_W-1:0] SELF_LIM = TIMER_W'(SELF_MIN_CLKS);
    localparam logic [TIMER_W-1:0] BAD_LIM  = TIMER_W'(BAD_MIN_CLKS);

    logic               cbr_q, armed_q, err_q, acc_open_q, have_acc_q;
    cyc_code_e          last_code_q;
    logic [1:0]         lanes_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [TIMER_W-1:0] timer_q;

    logic       any_s, any_p, acc_end;
    logic [1:0] accessed;
    logic       mism;
    lane_mode_e live_mode;
    cyc_code_e  live_code, fin_code;
    logic [1:0] fin_lanes;
    logic       fin_err;

    // Combined-strobe view and access boundaries.
    always_comb begin
        any_s     = ~&cas_s;
        any_p     = ~&cas_p;
        trk_en    = row_act & ~cbr_q;
        acc_start = trk_en & any_s & ~any_p;
        acc_end   = trk_en & ~any_s & any_p & acc_open_q;
    end

    // Live view of the access in progress.
    always_comb begin
        for (int i = 0; i < 2; i++) accessed[i] = (modes[i] != LM_IDLE);
        mism      = (&accessed) && (modes[0] != modes[1]);
        live_mode = accessed[0] ? modes[0] : modes[1];
        live_code = mode_to_code(live_mode, oe_seen);
    end

    // Final report assembled in the cycle the row closes.
    always_comb begin
        fin_err   = err_q | (acc_open_q & mism);
        fin_lanes = lanes_q | (acc_open_q ? accessed : 2'b00);
        if (fin_err)
            fin_code = CYC_PROTO_ERR;
        else if (cbr_q)
            fin_code = (timer_q >= SELF_LIM) ? CYC_SELF_REF :
                       (timer_q >= BAD_LIM)  ? CYC_PROTO_ERR : CYC_CBR_REF;
        else if (!have_acc_q && !acc_open_q)
            fin_code = CYC_ROW_REF;
        else
            fin_code = acc_open_q ? live_code : last_code_q;
    end

    // Tracks whether output enable went low during the current access.
    always_ff @(posedge clk) begin
        if (!rst_n)                  oe_seen <= 1'b0;
        else if (acc_start)          oe_seen <= ~oe_s;
        else if (acc_open_q && !oe_s) oe_seen <= 1'b1;
    end

    // Notes a column strobe falling while the row is closed.
    always_ff @(posedge clk) begin
        if (!rst_n)                         armed_q <= 1'b0;
        else if (ras_fall)                  armed_q <= 1'b0;
        else if (row_idle && any_s && !any_p) armed_q <= 1'b1;
    end

    // Row-period state: entry kind, width, accesses and errors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cbr_q       <= 1'b0;
            err_q       <= 1'b0;
            acc_open_q  <= 1'b0;
            have_acc_q  <= 1'b0;
            last_code_q <= CYC_NONE;
            lanes_q     <= '0;
            cnt_q       <= '0;
            timer_q     <= '0;
        end else if (ras_fall) begin
            cbr_q       <= any_s;
            err_q       <= armed_q & ~any_s;
            acc_open_q  <= 1'b0;
            have_acc_q  <= 1'b0;
            last_code_q <= CYC_NONE;
            lanes_q     <= '0;
            cnt_q       <= '0;
            timer_q     <= TIMER_W'(1);
        end else if (row_act) begin
            if (timer_q < SELF_LIM) timer_q <= timer_q + 1'b1;
            if (acc_start) begin
                acc_open_q <= 1'b1;
                if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
            end
            if (acc_end) begin
                acc_open_q  <= 1'b0;
                have_acc_q  <= 1'b1;
                last_code_q <= live_code;
                lanes_q     <= lanes_q | accessed;
                err_q       <= err_q | mism;
            end
        end else if (ras_rise) begin
            acc_open_q <= 1'b0;
            cbr_q      <= 1'b0;
        end
    end

    // Registers the report and the done pulse when the row closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code    <= CYC_NONE;
            lane_hi <= 1'b0;
            lane_lo <= 1'b0;
            cnt     <= '0;
            done    <= 1'b0;
        end else if (ras_rise) begin
            code    <= fin_code;
            lane_hi <= fin_lanes[1];
            lane_lo <= fin_lanes[0];
            cnt     <= cnt_q;
            done    <= 1'b1;
        end else begin
            done    <= 1'b0;
        end
    end
endmodule

// File: rtl/dram_cycle_classifier.sv
// Top of the DRAM strobe cycle classifier.
// Resynchronises the five strobes, derives edges, runs one mode tracker
// per byte lane and the row-period logic that issues the report.
// Assumes: the sample clock is several times faster than the shortest
// strobe pulse so every edge is seen as a distinct sample.
module dram_cycle_classifier
    import dcc_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int SELF_MIN_CLKS = 20000,
    parameter int BAD_MIN_CLKS  = 2000,
    parameter int CNT_W         = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic             ucas_n,
    input  logic             lcas_n,
    input  logic             we_n,
    input  logic             oe_n,
    output logic [3:0]       cyc_code,
    output logic             lane_hi,
    output logic             lane_lo,
    output logic [CNT_W-1:0] page_cnt,
    output logic             cyc_done
);
    localparam int NLANE = 2;
    localparam int NSIG  = 3 + NLANE;

    logic [NSIG-1:0]  s_vec;
    logic             s_ras, s_we, s_oe;
    logic [NLANE-1:0] s_cas;
    logic             p_ras, p_we;
    logic [NLANE-1:0] p_cas;
    logic             ras_fall, ras_rise, row_act, row_idle, we_fall;
    logic             trk_en, acc_start, oe_seen;
    lane_mode_e [NLANE-1:0] lane_mode;
    cyc_code_e        code_e;

    dcc_sync #(.W(NSIG), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({oe_n, we_n, ucas_n, lcas_n, ras_n}),
        .q     (s_vec)
    );

    assign s_ras = s_vec[0];
    assign s_cas = s_vec[2:1];
    assign s_we  = s_vec[3];
    assign s_oe  = s_vec[4];

    // Keeps the previous synchronised sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_ras <= 1'b1;
            p_cas <= '1;
            p_we  <= 1'b1;
        end else begin
            p_ras <= s_ras;
            p_cas <= s_cas;
            p_we  <= s_we;
        end
    end

    // Edge and level qualifiers shared by the sub-blocks.
    always_comb begin
        ras_fall = p_ras & ~s_ras;
        ras_rise = ~p_ras & s_ras;
        row_act  = ~p_ras & ~s_ras;
        row_idle = p_ras & s_ras;
        we_fall  = p_we & ~s_we;
    end

    genvar g;
    generate
        for (g = 0; g < NLANE; g++) begin : g_lane
            dcc_lane_track u_lane (
                .clk       (clk),
                .rst_n     (rst_n),
                .clr       (ras_fall),
                .trk_en    (trk_en),
                .acc_start (acc_start),
                .cas_s     (s_cas[g]),
                .cas_p     (p_cas[g]),
                .we_s      (s_we),
                .we_fall   (we_fall),
                .oe_seen   (oe_seen),
                .mode      (lane_mode[g])
            );
        end
    endgenerate

    dcc_period #(
        .SELF_MIN_CLKS (SELF_MIN_CLKS),
        .BAD_MIN_CLKS  (BAD_MIN_CLKS),
        .CNT_W         (CNT_W)
    ) u_period (
        .clk       (clk),
        .rst_n     (rst_n),
        .ras_fall  (ras_fall),
        .ras_rise  (ras_rise),
        .row_act   (row_act),
        .row_idle  (row_idle),
        .cas_s     (s_cas),
        .cas_p     (p_cas),
        .oe_s      (s_oe),
        .modes     (lane_mode),
        .trk_en    (trk_en),
        .acc_start (acc_start),
        .oe_seen   (oe_seen),
        .code      (code_e),
        .lane_hi   (lane_hi),
        .lane_lo   (lane_lo),
        .cnt       (page_cnt),
        .done      (cyc_done)
    );

    assign cyc_code = code_e;
endmodule

// File: rtl/dcc_checker.sv
// Port-level properties of the cycle classifier report.
// Assumes: bound to every instance of dram_cycle_classifier.
module dcc_checker #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       cyc_code,
    input logic             lane_hi,
    input logic             lane_lo,
    input logic [CNT_W-1:0] page_cnt,
    input logic             cyc_done
);
    logic is_ref, is_acc;
    assign is_ref = (cyc_code == 4'd6) || (cyc_code == 4'd7) || (cyc_code == 4'd8);
    assign is_acc = (cyc_code >= 4'd1) && (cyc_code <= 4'd5);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_done);

    assert_report_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_done |=> (cyc_done || $stable(cyc_code)));

    assert_done_has_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |-> (cyc_code != 4'd0));

    // R3, R4 and R5: refresh reports never name a lane
    assert_refresh_no_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && is_ref) |-> (!lane_hi && !lane_lo));

    assert_row_ref_no_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && cyc_code == 4'd6) |-> (page_cnt == '0));

    assert_access_has_lane_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && is_acc) |-> (lane_hi || lane_lo));

    assert_access_counted_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && is_acc) |-> (page_cnt != '0));
endmodule

bind dram_cycle_classifier dcc_checker #(.CNT_W(CNT_W)) u_dcc_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_code (cyc_code),
    .lane_hi  (lane_hi),
    .lane_lo  (lane_lo),
    .page_cnt (page_cnt),
    .cyc_done (cyc_done)
);

// File: tb/sim_dram_cycle_classifier.sv
// Directed bench for the cycle classifier: one task per bus scenario.
module sim_dram_cycle_classifier;
    localparam int CNT_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [3:0]       cyc_code;
    logic             lane_hi, lane_lo, cyc_done;
    logic [CNT_W-1:0] page_cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit fin   = 1'b0;

    always #2.5 clk = ~clk;

    dram_cycle_classifier #(
        .SYNC_STAGES   (2),
        .SELF_MIN_CLKS (40),
        .BAD_MIN_CLKS  (20),
        .CNT_W         (CNT_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
        .we_n(we_n), .oe_n(oe_n), .cyc_code(cyc_code), .lane_hi(lane_hi),
        .lane_lo(lane_lo), .page_cnt(page_cnt), .cyc_done(cyc_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Closes the row, waits for the report and compares it.
    task automatic end_period(input string req, input int code, input int hi,
                              input int lo, input int cnt);
        bit seen = 1'b0;
        @(negedge clk) ras_n = 1'b1;
        for (int i = 0; i < 12 && !seen; i++) begin
            @(negedge clk);
            if (cyc_done) seen = 1'b1;
        end
        chk({req, " done"}, int'(seen), 1);
        chk({req, " code"}, int'(cyc_code), code);
        chk({req, " lane_hi"}, int'(lane_hi), hi);
        chk({req, " lane_lo"}, int'(lane_lo), lo);
        chk({req, " count"}, int'(page_cnt), cnt);
        @(negedge clk);
        chk("R2 done one cycle", int'(cyc_done), 0);
    endtask

    task automatic t_reset();
        chk("R1 code", int'(cyc_code), 0);
        chk("R1 lanes", int'({lane_hi, lane_lo}), 0);
        chk("R1 count", int'(page_cnt), 0);
        chk("R1 done", int'(cyc_done), 0);
    endtask

    task automatic t_row_only();
        @(negedge clk) ras_n = 1'b0; idle(6);
        end_period("R3", 6, 0, 0, 0);
        idle(5);
        chk("R2 hold", int'(cyc_code), 6);
    endtask

    task automatic t_read_word();
        @(negedge clk) ras_n = 1'b0; idle(3);
        ucas_n = 1'b0; lcas_n = 1'b0; oe_n = 1'b0; idle(4);
        ucas_n = 1'b1; lcas_n = 1'b1; oe_n = 1'b1; idle(2);
        end_period("R6 read", 1, 1, 1, 1);
    endtask

    task automatic t_read_noout_lower();
        @(negedge clk) ras_n = 1'b0; idle(3);
        lcas_n = 1'b0; idle(4);
        lcas_n = 1'b1; idle(2);
        end_period("R6 R10 read no output lower", 2, 0, 1, 1);
    endtask

    task automatic t_early_upper();
        @(negedge clk) ras_n = 1'b0; idle(3);
        we_n = 1'b0; idle(2);
        ucas_n = 1'b0; idle(3);
        ucas_n = 1'b1; idle(2);
        we_n = 1'b1;
        end_period("R7 R10 early upper", 3, 1, 0, 1);
    endtask

    task automatic t_delayed();
        @(negedge clk) ras_n = 1'b0; idle(3);
        ucas_n = 1'b0; lcas_n = 1'b0; idle(3);
        we_n = 1'b0; idle(3);
        ucas_n = 1'b1; lcas_n = 1'b1; idle(2);
        we_n = 1'b1;
        end_period("R8 delayed", 4, 1, 1, 1);
    endtask

    task automatic t_rmw();
        @(negedge clk) ras_n = 1'b0; idle(3);
        ucas_n = 1'b0; lcas_n = 1'b0; idle(2);
        oe_n = 1'b0; idle(3);
        oe_n = 1'b1; idle(2);
        we_n = 1'b0; idle(3);
        ucas_n = 1'b1; lcas_n = 1'b1; idle(2);
        we_n = 1'b1;
        end_period("R9 rmw", 5, 1, 1, 1);
    endtask

    task automatic t_page();
        @(negedge clk) ras_n = 1'b0; idle(3);
        ucas_n = 1'b0; lcas_n = 1'b0; oe_n = 1'b0; idle(3);
        ucas_n = 1'b1; lcas_n = 1'b1; oe_n = 1'b1; idle(3);
        lcas_n = 1'b0; oe_n = 1'b0; idle(3);
        lcas_n = 1'b1; oe_n = 1'b1; idle(3);
        we_n = 1'b0; idle(2);
        ucas_n = 1'b0; idle(3);
        ucas_n = 1'b1; idle(2);
        we_n = 1'b1;
        end_period("R11 page last access", 3, 1, 1, 3);
    endtask

    task automatic t_cbr();
        @(negedge clk) ucas_n = 1'b0; lcas_n = 1'b0; idle(3);
        ras_n = 1'b0; idle(8);
        end_period("R4 strobe-first", 7, 0, 0, 0);
        ucas_n = 1'b1; lcas_n = 1'b1; idle(3);
    endtask

    task automatic t_hidden();
        @(negedge clk) ras_n = 1'b0; idle(3);
        ucas_n = 1'b0; lcas_n = 1'b0; oe_n = 1'b0; idle(4);
        end_period("R6 read before hidden", 1, 1, 1, 1);
        oe_n = 1'b1; idle(3);
        ras_n = 1'b0; idle(6);
        end_period("R4 hidden refresh", 7, 0, 0, 0);
        ucas_n = 1'b1; lcas_n = 1'b1; idle(3);
    endtask

    task automatic t_self();
        @(negedge clk) lcas_n = 1'b0; idle(3);
        ras_n = 1'b0; idle(60);
        end_period("R5 self refresh", 8, 0, 0, 0);
        lcas_n = 1'b1; idle(3);
    endtask

    task automatic t_band();
        @(negedge clk) ucas_n = 1'b0; idle(3);
        ras_n = 1'b0; idle(30);
        end_period("R14 transition band", 9, 0, 0, 0);
        ucas_n = 1'b1; idle(3);
    endtask

    task automatic t_mismatch();
        @(negedge clk) ras_n = 1'b0; idle(3);
        lcas_n = 1'b0; idle(3);
        we_n = 1'b0; idle(3);
        ucas_n = 1'b0; idle(3);
        ucas_n = 1'b1; lcas_n = 1'b1; idle(2);
        we_n = 1'b1;
        end_period("R12 lane mode mismatch", 9, 1, 1, 1);
    endtask

    task automatic t_aborted();
        @(negedge clk) ucas_n = 1'b0; idle(3);
        ucas_n = 1'b1; idle(3);
        ras_n = 1'b0; idle(5);
        end_period("R13 aborted strobe-first", 9, 0, 0, 0);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(4);
        t_reset();
        t_row_only();         idle(4);
        t_read_word();        idle(4);
        t_read_noout_lower(); idle(4);
        t_early_upper();      idle(4);
        t_delayed();          idle(4);
        t_rmw();              idle(4);
        t_page();             idle(4);
        t_cbr();              idle(4);
        t_hidden();           idle(4);
        t_self();             idle(4);
        t_band();             idle(4);
        t_mismatch();         idle(4);
        t_aborted();          idle(4);
        t_read_word();        idle(4);
        fin = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!fin) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got 0 expected 1 (run completed)");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule